// File: doc/BRIEF.md
# Instruction Bundle Slot Sequencer

This block sits between instruction fetch and issue. It takes one 128-bit instruction bundle at a time over a valid/ready handshake and returns the bundle's instructions one per cycle on an output stream, which also uses valid/ready. The low five bits of every bundle hold a template code. The code is looked up in a fixed table that gives the execution unit class of each slot, where instruction-group stops fall, and whether the bundle has two items (one normal slot plus one double-wide slot) instead of three.

Each issued item carries the raw slot bits, a unit-class code, a stop flag and a last-item flag. The stop flag marks the end of an instruction group. The last-item flag marks the final item of the bundle. A bundle whose fetch address is not on a 16-byte boundary, or whose template code is not in the table, is consumed at once and produces no items. The block raises a one-cycle error pulse for it instead. Only one bundle is held at a time.

Top module: `bundleSequencer`

## Requirements
- R1: While reset is high and on the cycle after it, `outValid`, `alignErr` and `tmplErr` are 0 and `inReady` is 1. Reset is synchronous and active high.
- R2: Bundle layout. The template code is bits [4:0]. Slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. For an ordinary template the items come out in slot order, each on `outSlot` zero-extended from 41 to 82 bits.
- R3: Unit codes on `outUnit` are M=0, I=1, A=2, F=3, B=4. With g = code[4:1], the units per item are: g0 M,I,I; g1 M,I,I; g2 M,wide-I; g4 M,M,I; g5 M,M,I; g6 M,F,I; g7 M,M,F; g8 M,I,B; g9 M,B,B; g10 A,A,I; g11 B,B,B; g12 M,M,B; g14 M,F,B; g15 M,wide-B.
- R4: Groups 2 and 15 are long templates. They issue exactly two items: slot 0 first, then bits [127:46] as a single 82-bit item.
- R5: `outStop` is 1 on the item just before a stop. Group 1 has a stop after slot 1. Group 5 has a stop after slot 0. When code bit 0 is 1, there is also a stop after the bundle's final item. No other item has the flag set.
- R6: `outLast` is 1 on the final item of a bundle (the third, or the second for a long template) and 0 on every other item.
- R7: If a bundle is accepted with a fetch address whose low four bits are nonzero, `alignErr` is 1 in the following cycle and no item from that bundle is issued.
- R8: Groups 3 and 13 (codes 6, 7, 26, 27) are undefined. Accepting such a bundle sets `tmplErr` to 1 in the following cycle and issues no item. A bundle can raise both errors at once.
- R9: `inReady` is 0 while any item of the current bundle is pending. It returns to 1 in the cycle after the final item is taken.
- R10: While `outValid` is 1 and `outReady` is 0, the presented item and all of its flags stay unchanged.
- R11: A reset part-way through a bundle discards the remaining items. The block is then idle and ready for a new bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A fetched bundle is offered |
| inReady | output | 1 | Sequencer can take a bundle |
| inBundle | input | 128 | Bundle bits |
| inAddr | input | ADDR_W | Fetch address of the bundle |
| outValid | output | 1 | An item is presented |
| outReady | input | 1 | Consumer takes the presented item |
| outSlot | output | 82 | Slot bits (zero-extended, or the double-wide slot) |
| outUnit | output | 3 | Unit class of the item |
| outStop | output | 1 | Instruction group ends after this item |
| outLast | output | 1 | Final item of the bundle |
| alignErr | output | 1 | Pulse: last accepted bundle was misaligned |
| tmplErr | output | 1 | Pulse: last accepted bundle had an undefined template |

## Verification
A corrupted slot counter or latched template entry shows up at the ports on the very next presented item. It appears as a wrong slot field, a unit code that does not match the table, a stop or last flag on the wrong item, or a missing or extra item, which in turn leaves `inReady` low too long or raises it too early. Every one of the 32 template codes is swept with several payloads, and the consumer is stalled on a different item each time, so a mismatch in the lookup, the slot order or the hold behaviour is seen within a few cycles of the bundle entering. Both error paths are driven for every misaligned offset, and by themselves and together.

// File: rtl/bseqPkg.sv
package bseqPkg;

  localparam int TMPL_W   = 5;
  localparam int SLOT_W   = 41;
  localparam int NSLOT    = 3;
  localparam int BUNDLE_W = TMPL_W + NSLOT * SLOT_W;
  localparam int WIDE_W   = 2 * SLOT_W;
  localparam int PAY_W    = BUNDLE_W - TMPL_W;
  localparam int IDX_W    = $clog2(NSLOT);

  typedef enum logic [2:0] {
    UNIT_M = 3'd0,
    UNIT_I = 3'd1,
    UNIT_A = 3'd2,
    UNIT_F = 3'd3,
    UNIT_B = 3'd4
  } unitT;

  typedef struct packed {
    logic             legal;
    logic             isLong;
    unitT             u0;
    unitT             u1;
    unitT             u2;
    logic [NSLOT-1:0] stopAt;
  } tmplT;

  typedef struct packed {
    logic load;
    logic advance;
    logic clear;
  } strobeT;

  function automatic tmplT mkEntry(input logic lg, input logic ln,
                                   input unitT a, input unitT b, input unitT c,
                                   input logic [NSLOT-1:0] st);
    tmplT e;
    e.legal  = lg;
    e.isLong = ln;
    e.u0     = a;
    e.u1     = b;
    e.u2     = c;
    e.stopAt = st;
    return e;
  endfunction

  function automatic tmplT decodeTmpl(input logic [TMPL_W-1:0] code);
    tmplT e;
    case (code[4:1])
      4'd0:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_I, UNIT_I, 3'b000);
      4'd1:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_I, UNIT_I, 3'b010);
      4'd2:    e = mkEntry(1'b1, 1'b1, UNIT_M, UNIT_I, UNIT_M, 3'b000);
      4'd4:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_M, UNIT_I, 3'b000);
      4'd5:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_M, UNIT_I, 3'b001);
      4'd6:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_F, UNIT_I, 3'b000);
      4'd7:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_M, UNIT_F, 3'b000);
      4'd8:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_I, UNIT_B, 3'b000);
      4'd9:    e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_B, UNIT_B, 3'b000);
      4'd10:   e = mkEntry(1'b1, 1'b0, UNIT_A, UNIT_A, UNIT_I, 3'b000);
      4'd11:   e = mkEntry(1'b1, 1'b0, UNIT_B, UNIT_B, UNIT_B, 3'b000);
      4'd12:   e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_M, UNIT_B, 3'b000);
      4'd14:   e = mkEntry(1'b1, 1'b0, UNIT_M, UNIT_F, UNIT_B, 3'b000);
      4'd15:   e = mkEntry(1'b1, 1'b1, UNIT_M, UNIT_B, UNIT_M, 3'b000);
      default: e = mkEntry(1'b0, 1'b0, UNIT_M, UNIT_M, UNIT_M, 3'b000);
    endcase
    // code bit 0 closes the group after the bundle's final item
    if (code[0]) begin
      if (e.isLong) e.stopAt[1] = 1'b1;
      else          e.stopAt[NSLOT-1] = 1'b1;
    end
    return e;
  endfunction

endpackage

// File: rtl/bseqTemplateRom.sv
module bseqTemplateRom
  import bseqPkg::*;
(
  input  logic [TMPL_W-1:0] tmplCode,
  output tmplT              entry
);

  always_comb entry = decodeTmpl(tmplCode);

endmodule

// File: rtl/bseqCtrl.sv
module bseqCtrl
  import bseqPkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  input  logic   alignOk,
  input  logic   tmplLegal,
  input  logic   isLast,
  input  logic   outReady,
  output logic   inReady,
  output logic   outValid,
  output logic   alignErr,
  output logic   tmplErr,
  output strobeT strobe
);

  logic busyQ;
  logic accept;

  assign inReady  = !busyQ;
  assign outValid = busyQ;
  assign accept   = inValid && !busyQ;

  always_comb begin
    strobe.load    = accept && alignOk && tmplLegal;
    strobe.advance = busyQ && outReady && !isLast;
    strobe.clear   = busyQ && outReady && isLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ    <= 1'b0;
      alignErr <= 1'b0;
      tmplErr  <= 1'b0;
    end else begin
      if (strobe.load)       busyQ <= 1'b1;
      else if (strobe.clear) busyQ <= 1'b0;
      alignErr <= accept && !alignOk;
      tmplErr  <= accept && !tmplLegal;
    end
  end

endmodule

// File: rtl/bseqData.sv
module bseqData
  import bseqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [PAY_W-1:0]  payload,
  input  tmplT              entryIn,
  output logic [WIDE_W-1:0] outSlot,
  output logic [2:0]        outUnit,
  output logic              outStop,
  output logic              isLast
);

  logic [PAY_W-1:0]  payQ;
  logic              longQ;
  unitT              unitQ [NSLOT];
  logic [NSLOT-1:0]  stopQ;
  logic [IDX_W-1:0]  idxQ;
  logic [SLOT_W-1:0] slotField [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_field
    assign slotField[s] = payQ[s*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      payQ  <= '0;
      longQ <= 1'b0;
      stopQ <= '0;
      idxQ  <= '0;
      for (int s = 0; s < NSLOT; s++) unitQ[s] <= UNIT_M;
    end else if (strobe.load) begin
      payQ     <= payload;
      longQ    <= entryIn.isLong;
      stopQ    <= entryIn.stopAt;
      unitQ[0] <= entryIn.u0;
      unitQ[1] <= entryIn.u1;
      unitQ[2] <= entryIn.u2;
      idxQ     <= '0;
    end else if (strobe.advance) begin
      idxQ <= idxQ + 1'b1;
    end else if (strobe.clear) begin
      idxQ <= '0;
    end
  end

  assign isLast = (idxQ == (longQ ? IDX_W'(1) : IDX_W'(NSLOT - 1)));

  always_comb begin
    outSlot = '0;
    outUnit = unitQ[0];
    outStop = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (idxQ == IDX_W'(s)) begin
        outSlot = {{(WIDE_W - SLOT_W){1'b0}}, slotField[s]};
        outUnit = unitQ[s];
        outStop = stopQ[s];
      end
    end
    if (longQ && idxQ == IDX_W'(1)) outSlot = payQ[PAY_W-1 -: WIDE_W];
  end

endmodule

// File: rtl/bundleSequencer.sv
module bundleSequencer
  import bseqPkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int BUNDLE_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [BUNDLE_W-1:0] inBundle,
  input  logic [ADDR_W-1:0]   inAddr,
  output logic                outValid,
  input  logic                outReady,
  output logic [WIDE_W-1:0]   outSlot,
  output logic [2:0]          outUnit,
  output logic                outStop,
  output logic                outLast,
  output logic                alignErr,
  output logic                tmplErr
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BUNDLE_BYTES - 1);

  tmplT   entry;
  strobeT strobe;
  logic   alignOk;
  logic   isLast;

  assign alignOk = ((inAddr & ALIGN_MASK) == '0);
  assign outLast = isLast;

  bseqTemplateRom i_rom (
    .tmplCode (inBundle[TMPL_W-1:0]),
    .entry    (entry)
  );

  bseqCtrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .alignOk   (alignOk),
    .tmplLegal (entry.legal),
    .isLast    (isLast),
    .outReady  (outReady),
    .inReady   (inReady),
    .outValid  (outValid),
    .alignErr  (alignErr),
    .tmplErr   (tmplErr),
    .strobe    (strobe)
  );

  bseqData i_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .payload (inBundle[BUNDLE_W-1:TMPL_W]),
    .entryIn (entry),
    .outSlot (outSlot),
    .outUnit (outUnit),
    .outStop (outStop),
    .isLast  (isLast)
  );

endmodule

// File: rtl/bseqChecker.sv
module bseqChecker #(
  parameter int ADDR_W       = 64,
  parameter int BUNDLE_BYTES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [ADDR_W-1:0] inAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [81:0]       outSlot,
  input logic [2:0]        outUnit,
  input logic              outLast,
  input logic              alignErr,
  input logic              tmplErr
);

  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(BUNDLE_BYTES - 1);

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady); // R9

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outLast |=> inReady && !outValid); // R9

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outSlot) && $stable(outUnit) && $stable(outLast)); // R10

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && ((inAddr & MASK) != '0) |=> alignErr && !outValid); // R7

  AST_TMPL_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    tmplErr |-> !outValid); // R8

  AST_UNIT_CODE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outUnit <= 3'd4); // R3

endmodule

bind bundleSequencer bseqChecker #(.ADDR_W(ADDR_W), .BUNDLE_BYTES(BUNDLE_BYTES)) i_chk (.*);

// File: tb/test_bundleSequencer.sv
module test_bundleSequencer;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic          inReady;
  logic [127:0]  inBundle;
  logic [63:0]   inAddr;
  logic          outValid;
  logic          outReady;
  logic [81:0]   outSlot;
  logic [2:0]    outUnit;
  logic          outStop;
  logic          outLast;
  logic          alignErr;
  logic          tmplErr;

  int  vecs = 0;
  int  fails = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  bundleSequencer i_bundleSequencer (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inBundle(inBundle), .inAddr(inAddr), .outValid(outValid),
    .outReady(outReady), .outSlot(outSlot), .outUnit(outUnit),
    .outStop(outStop), .outLast(outLast), .alignErr(alignErr),
    .tmplErr(tmplErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Unit table from the requirements (R3, R4, R5, R8): M0 I1 A2 F3 B4
  task automatic refTmpl(input logic [4:0] t, output bit legal, output bit isLong,
                         output logic [8:0] units, output logic [2:0] stops);
    legal = 1; isLong = 0; stops = 3'b000;
    case (t[4:1])
      4'd0:  units = {3'd1, 3'd1, 3'd0};
      4'd1:  begin units = {3'd1, 3'd1, 3'd0}; stops = 3'b010; end
      4'd2:  begin units = {3'd0, 3'd1, 3'd0}; isLong = 1; end
      4'd4:  units = {3'd1, 3'd0, 3'd0};
      4'd5:  begin units = {3'd1, 3'd0, 3'd0}; stops = 3'b001; end
      4'd6:  units = {3'd1, 3'd3, 3'd0};
      4'd7:  units = {3'd3, 3'd0, 3'd0};
      4'd8:  units = {3'd4, 3'd1, 3'd0};
      4'd9:  units = {3'd4, 3'd4, 3'd0};
      4'd10: units = {3'd1, 3'd2, 3'd2};
      4'd11: units = {3'd4, 3'd4, 3'd4};
      4'd12: units = {3'd4, 3'd0, 3'd0};
      4'd14: units = {3'd4, 3'd3, 3'd0};
      4'd15: begin units = {3'd0, 3'd4, 3'd0}; isLong = 1; end
      default: begin units = '0; legal = 0; end
    endcase
    if (t[0]) begin
      if (isLong) stops[1] = 1'b1;
      else        stops[2] = 1'b1;
    end
  endtask

  task automatic checkItem(input logic [127:0] b, input int i, input bit isLong,
                           input logic [8:0] units, input logic [2:0] stops, input int n);
    logic [81:0] expSlot;
    if (isLong && i == 1) expSlot = b[127:46];
    else                  expSlot = {41'b0, b[5 + 41*i +: 41]};
    chk("R2", "outValid", outValid, 1);
    chk(isLong ? "R4" : "R2", $sformatf("slot %0d", i), outSlot, expSlot);
    chk("R3", $sformatf("unit %0d", i), outUnit, units[3*i +: 3]);
    chk("R5", $sformatf("stop %0d", i), outStop, stops[i]);
    chk("R6", $sformatf("last %0d", i), outLast, (i == n - 1));
    chk("R9", "inReady busy", inReady, 0);
  endtask

  task automatic runBundle(input logic [4:0] t, input logic [63:0] addr,
                           input logic [122:0] pay, input int stallAt);
    logic [127:0] b;
    bit legal, isLong, misal;
    logic [8:0] units;
    logic [2:0] stops;
    int n;
    b = {pay, t};
    refTmpl(t, legal, isLong, units, stops);
    misal = (addr[3:0] != 4'd0);
    @(negedge clk);
    inBundle = b; inAddr = addr; inValid = 1'b1;
    chk("R9", "ready when idle", inReady, 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R7", "alignErr", alignErr, misal);
    chk("R8", "tmplErr", tmplErr, !legal);
    if (misal || !legal) begin
      chk("R7", "no item after error", outValid, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "still no item", outValid, 0);
      chk("R8", "ready after error", inReady, 1);
      return;
    end
    n = isLong ? 2 : 3;
    for (int i = 0; i < n; i++) begin
      if (i == stallAt) begin
        outReady = 1'b0;
        checkItem(b, i, isLong, units, stops, n);
        @(posedge clk);
        @(negedge clk);
        // R10: held item unchanged under stall
        checkItem(b, i, isLong, units, stops, n);
        outReady = 1'b1;
      end else begin
        checkItem(b, i, isLong, units, stops, n);
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R9", "idle after last", outValid, 0);
    chk("R9", "ready after last", inReady, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [122:0] pay;
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1; inBundle = '0; inAddr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "outValid in reset", outValid, 0);
    chk("R1", "inReady in reset", inReady, 1);
    chk("R1", "errors in reset", {alignErr, tmplErr}, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "outValid after reset", outValid, 0);
    chk("R1", "inReady after reset", inReady, 1);

    // Full template sweep with varied payloads and stall positions
    for (int t = 0; t < 32; t++) begin
      for (int p = 0; p < 3; p++) begin
        if (p == 0)      pay = '1;
        else if (p == 1) pay = {31{4'hA}};
        else             pay = {$urandom, $urandom, $urandom, $urandom};
        runBundle(5'(t), 64'(t * 4096 + p * 16), pay, (t + p) % 4);
      end
    end

    // R7: every misaligned offset, legal template
    for (int off = 1; off < 16; off++)
      runBundle(5'd8, 64'h1000 + 64'(off), {$urandom, $urandom, $urandom, $urandom}, 9);

    // R7 and R8 together
    runBundle(5'd26, 64'h2004, '1, 9);

    // R11: reset part-way through a bundle
    @(negedge clk);
    inBundle = {123'h1234_5678, 5'd0}; inAddr = 64'h3000; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R11", "first item out", outValid, 1);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "items dropped", outValid, 0);
    chk("R11", "ready again", inReady, 1);
    runBundle(5'd21, 64'h3010, {$urandom, $urandom, $urandom, $urandom}, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule